// File: doc/BRIEF.md
# USB High-Speed Detection Handshake Controller

This block sits on the device side of a USB 2.0 port and runs the speed negotiation that follows a bus reset. It watches the decoded line state (SE0, J, K), works out from how long each state has been held whether the hub is resetting the bus or letting it idle, and drives the chirp-K request and the two line loads: the full-speed pull-up and the high-speed termination. After it drives chirp K, it counts the alternating K/J chirps that the hub sends back. Once enough of them arrive in order, the device switches to high speed. If the hub does not answer in time, the device falls back to full speed.

In high-speed operation the controller treats a squelched bus (SE0) as idle. When the idle lasts long enough, it reverts to full-speed loading, waits a settle delay and reads the line. SE0 at that point means a reset, which starts a new handshake. J means a suspend. A K held during suspend marks a resume, and the handshake runs again once the K ends. Every duration is a cycle count set by a parameter, so simulation can use short values.

The state machine has seven states. FS_RUN is full-speed operation. CHIRP drives chirp K. HUB_WAIT counts the hub chirps. HS_RUN is high-speed operation. REVERT is full-speed loading while the line settles. SUSPEND is the suspended state. RESUME waits for the K to end. The transitions are:
- FS_RUN goes to CHIRP when a long SE0 is seen (reset), and to SUSPEND when a long J is seen.
- CHIRP goes to HUB_WAIT when the chirp timer expires.
- HUB_WAIT goes to HS_RUN once the full sequence of hub chirps has been counted, and to FS_RUN on timeout.
- HS_RUN goes to REVERT when the squelch idle lasts long enough.
- REVERT, once the settle delay ends, goes to CHIRP on SE0, to SUSPEND on J, and to FS_RUN on anything else.
- SUSPEND goes to CHIRP on a long SE0 and to RESUME on a qualified K.
- RESUME goes to CHIRP when the line leaves K.

Top module: `hs_negotiator`

## Requirements
- R1: After reset the block is in full-speed operation: `speed_hs`=0, `pullup_en`=1, `hs_term_en`=0, `chirp_k_drive`=0, `suspended`=0, and no event pulses.
- R2: `line_state` is coded as 00=SE0, 01=J, 10=K, 11=ignored. In full-speed operation, or in suspend, an SE0 held for RESET_CYC cycles gives a one-cycle `reset_evt` and starts the chirp. A shorter SE0 gives no event.
- R3: Chirp K (`chirp_k_drive`=1) lasts exactly CHIRP_CYC cycles.
- R4: A hub chirp counts only when J or K is held for at least CHIRP_MIN cycles. A shorter pulse is neither counted nor breaks the sequence.
- R5: After 2*CHIRP_PAIRS qualified chirps that alternate, starting with K, the block enters high speed: `speed_hs`=1, `pullup_en`=0, `hs_term_en`=1.
- R6: A qualified chirp with the same polarity as the previous one restarts the count. A repeated K counts as the first chirp of a new sequence; a leading or repeated J counts as none.
- R7: If the sequence is not complete within HUB_WAIT_CYC cycles after chirp K ends, the block returns to full speed. An SE0 left over from that same reset does not raise a second `reset_evt` until the line has left SE0.
- R8: In high speed, J or K activity keeps the mode. SE0 held for IDLE_CYC cycles drops `speed_hs`, sets `pullup_en`=1 and sets `hs_term_en`=0.
- R9: After a revert, the line is sampled once SETTLE_CYC cycles have passed. SE0 gives `reset_evt` and a new chirp; J gives `suspend_evt` and `suspended`=1. The two events never occur together.
- R10: In full-speed operation, J held for IDLE_CYC cycles gives `suspend_evt` and `suspended`=1.
- R11: In suspend, K held for CHIRP_MIN cycles starts a resume. When the line leaves K, `suspended` drops and the chirp handshake runs again.
- R12: The pull-up and the termination are never enabled together, and chirp K is never driven in high speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_state | input | 2 | Decoded line: 00 SE0, 01 J, 10 K, 11 ignored |
| chirp_k_drive | output | 1 | Request to drive chirp K |
| pullup_en | output | 1 | Full-speed D+ pull-up enable |
| hs_term_en | output | 1 | High-speed termination enable |
| speed_hs | output | 1 | 1 = high-speed mode, 0 = full speed |
| suspended | output | 1 | Device is suspended |
| reset_evt | output | 1 | One-cycle pulse: bus reset recognised |
| suspend_evt | output | 1 | One-cycle pulse: suspend recognised |

## Verification
The handshake is tried with four kinds of hub reply:
- A clean alternating K/J train, which must reach high speed.
- A train with a repeated K and a short J glitch. It must take one more chirp than a counter that ignores order or width would need, so it separates correct qualification from a naive count.
- Silence, which must time out to full speed without a second reset from the SE0 still on the line.
- A handshake entered from resume rather than from reset.

After a high-speed idle, the line is sampled once with SE0 and once with J, which separates the reset branch from the suspend branch. Short SE0 and short J runs in full speed, and J bursts in high speed, show that the idle thresholds are measured and not triggered by any single state.

// File: rtl/hsneg_pkg.sv
package hsneg_pkg;

    // Decoded bus condition presented by the line receiver
    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_t;

    // Negotiation controller states
    typedef enum logic [2:0] {
        ST_FS_RUN,
        ST_CHIRP,
        ST_HUB_WAIT,
        ST_HS_RUN,
        ST_REVERT,
        ST_SUSPEND,
        ST_RESUME
    } neg_state_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/hsneg_line_tracker.sv
module hsneg_line_tracker
    import hsneg_pkg::*;
#(
    parameter int RUN_W   = 8,
    parameter int RUN_MAX = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  line_t            line_in,
    output line_t            ls_q,
    output logic [RUN_W-1:0] run_len
);

    localparam logic [RUN_W-1:0] RUN_SAT = RUN_W'(RUN_MAX);

    // run_len = cycles the registered state has been held, minus one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ls_q    <= LS_SE1;
            run_len <= '0;
        end else begin
            ls_q <= line_in;
            if (line_in != ls_q) begin
                run_len <= '0;
            end else if (run_len != RUN_SAT) begin
                run_len <= run_len + 1'b1;
            end
        end
    end

endmodule

// File: rtl/hsneg_timer.sv
module hsneg_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             expired
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/hsneg_chirp_qual.sv
module hsneg_chirp_qual
    import hsneg_pkg::*;
#(
    parameter int CHIRP_MIN = 8,
    parameter int NEED      = 6,
    parameter int RUN_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  line_t            ls,
    input  logic [RUN_W-1:0] run_len,
    output logic             done
);

    localparam int               CNT_W  = $clog2(NEED + 1);
    localparam logic [RUN_W-1:0] QUAL_AT = RUN_W'(CHIRP_MIN - 1);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(NEED);

    logic [CNT_W-1:0] cnt_q;
    line_t            last_q;
    logic             qual;
    logic             is_chirp;

    assign is_chirp = (ls == LS_J) || (ls == LS_K);
    // a chirp qualifies exactly once, on the cycle its run reaches the minimum
    assign qual     = is_chirp && (run_len == QUAL_AT);

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q  <= '0;
            last_q <= LS_SE0;
        end else if (qual) begin
            if ((last_q != LS_SE0) && (ls != last_q)) begin
                if (cnt_q != CNT_TOP) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                last_q <= ls;
            end else if (ls == LS_K) begin
                cnt_q  <= CNT_W'(1);
                last_q <= LS_K;
            end else begin
                cnt_q  <= '0;
                last_q <= LS_SE0;
            end
        end
    end

    assign done = (cnt_q == CNT_TOP);

endmodule

// File: rtl/hs_negotiator.sv
module hs_negotiator
    import hsneg_pkg::*;
#(
    parameter int RESET_CYC    = 64,
    parameter int CHIRP_CYC    = 48,
    parameter int HUB_WAIT_CYC = 200,
    parameter int CHIRP_MIN    = 8,
    parameter int CHIRP_PAIRS  = 3,
    parameter int IDLE_CYC     = 100,
    parameter int SETTLE_CYC   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] line_state,
    output logic       chirp_k_drive,
    output logic       pullup_en,
    output logic       hs_term_en,
    output logic       speed_hs,
    output logic       suspended,
    output logic       reset_evt,
    output logic       suspend_evt
);

    localparam int RUN_MAX = max3(RESET_CYC, IDLE_CYC, CHIRP_MIN) - 1;
    localparam int RUN_W   = $clog2(RUN_MAX + 2);
    localparam int TMR_MAX = max3(CHIRP_CYC, HUB_WAIT_CYC, SETTLE_CYC);
    localparam int TMR_W   = $clog2(TMR_MAX + 1);
    localparam int NEED    = 2 * CHIRP_PAIRS;

    localparam logic [RUN_W-1:0] RESET_TH = RUN_W'(RESET_CYC - 1);
    localparam logic [RUN_W-1:0] IDLE_TH  = RUN_W'(IDLE_CYC - 1);
    localparam logic [RUN_W-1:0] CHIRP_TH = RUN_W'(CHIRP_MIN - 1);
    localparam logic [TMR_W-1:0] T_CHIRP  = TMR_W'(CHIRP_CYC - 1);
    localparam logic [TMR_W-1:0] T_WAIT   = TMR_W'(HUB_WAIT_CYC - 1);
    localparam logic [TMR_W-1:0] T_SETTLE = TMR_W'(SETTLE_CYC - 1);

    neg_state_t       state_q, state_d;
    line_t            ls_q;
    logic [RUN_W-1:0] run_len;
    logic             tmr_load, tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic             chirps_done;
    logic             need_change_q;
    logic             hit_reset, hit_susp;
    logic             se0_long, j_idle, se0_idle, k_held;

    hsneg_line_tracker #(
        .RUN_W   (RUN_W),
        .RUN_MAX (RUN_MAX)
    ) u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_in (line_t'(line_state)),
        .ls_q    (ls_q),
        .run_len (run_len)
    );

    hsneg_timer #(
        .TMR_W (TMR_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    hsneg_chirp_qual #(
        .CHIRP_MIN (CHIRP_MIN),
        .NEED      (NEED),
        .RUN_W     (RUN_W)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state_q != ST_HUB_WAIT),
        .ls      (ls_q),
        .run_len (run_len),
        .done    (chirps_done)
    );

    // Held-condition decodes on the registered line
    assign se0_long = (ls_q == LS_SE0) && (run_len >= RESET_TH);
    assign se0_idle = (ls_q == LS_SE0) && (run_len >= IDLE_TH);
    assign j_idle   = (ls_q == LS_J)   && (run_len >= IDLE_TH);
    assign k_held   = (ls_q == LS_K)   && (run_len >= CHIRP_TH);

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        hit_reset = 1'b0;
        hit_susp  = 1'b0;
        unique case (state_q)
            ST_FS_RUN: begin
                if (se0_long && !need_change_q) begin
                    state_d   = ST_CHIRP;
                    hit_reset = 1'b1;
                end else if (j_idle) begin
                    state_d  = ST_SUSPEND;
                    hit_susp = 1'b1;
                end
            end
            ST_CHIRP: begin
                if (tmr_exp) state_d = ST_HUB_WAIT;
            end
            ST_HUB_WAIT: begin
                if (chirps_done)  state_d = ST_HS_RUN;
                else if (tmr_exp) state_d = ST_FS_RUN;
            end
            ST_HS_RUN: begin
                if (se0_idle) state_d = ST_REVERT;
            end
            ST_REVERT: begin
                if (tmr_exp) begin
                    if (ls_q == LS_SE0) begin
                        state_d   = ST_CHIRP;
                        hit_reset = 1'b1;
                    end else if (ls_q == LS_J) begin
                        state_d  = ST_SUSPEND;
                        hit_susp = 1'b1;
                    end else begin
                        state_d = ST_FS_RUN;
                    end
                end
            end
            ST_SUSPEND: begin
                if (se0_long) begin
                    state_d   = ST_CHIRP;
                    hit_reset = 1'b1;
                end else if (k_held) begin
                    state_d = ST_RESUME;
                end
            end
            ST_RESUME: begin
                if (ls_q != LS_K) state_d = ST_CHIRP;
            end
            default: state_d = ST_FS_RUN;
        endcase
    end

    // Timer is reloaded on every state change with the entered state's window
    assign tmr_load = (state_d != state_q);
    always_comb begin
        unique case (state_d)
            ST_CHIRP:    tmr_val = T_CHIRP;
            ST_HUB_WAIT: tmr_val = T_WAIT;
            ST_REVERT:   tmr_val = T_SETTLE;
            default:     tmr_val = '0;
        endcase
    end

    // State register, event pulses and re-arm latch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_FS_RUN;
            reset_evt     <= 1'b0;
            suspend_evt   <= 1'b0;
            need_change_q <= 1'b0;
        end else begin
            state_q     <= state_d;
            reset_evt   <= hit_reset;
            suspend_evt <= hit_susp;
            if ((state_q == ST_HUB_WAIT) && (state_d == ST_FS_RUN)) begin
                need_change_q <= 1'b1;
            end else if (ls_q != LS_SE0) begin
                need_change_q <= 1'b0;
            end
        end
    end

    // Outputs decoded from the state
    always_comb begin
        chirp_k_drive = (state_q == ST_CHIRP);
        speed_hs      = (state_q == ST_HS_RUN);
        hs_term_en    = (state_q == ST_HS_RUN);
        pullup_en     = (state_q != ST_HS_RUN);
        suspended     = (state_q == ST_SUSPEND);
    end

endmodule

// File: rtl/hsneg_checker.sv
module hsneg_checker #(
    parameter int CHIRP_CYC = 48
) (
    input logic clk,
    input logic rst_n,
    input logic chirp_k_drive,
    input logic pullup_en,
    input logic hs_term_en,
    input logic speed_hs,
    input logic suspended,
    input logic reset_evt,
    input logic suspend_evt
);

    localparam int            CL_W   = $clog2(CHIRP_CYC + 2);
    localparam logic [CL_W-1:0] CL_TOP = CL_W'(CHIRP_CYC + 1);

    logic [CL_W-1:0] chirp_len;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chirp_len <= '0;
        end else if (!chirp_k_drive) begin
            chirp_len <= '0;
        end else if (chirp_len != CL_TOP) begin
            chirp_len <= chirp_len + 1'b1;
        end
    end

    // R3: chirp window length
    p_chirp_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chirp_k_drive) |-> (chirp_len == CL_W'(CHIRP_CYC)));

    // R2: a reset event starts the chirp and lasts one cycle
    p_reset_chirp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt |-> chirp_k_drive);
    p_reset_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        reset_evt |=> !reset_evt);

    // R5: entering high speed swaps the loads
    p_hs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(speed_hs) |-> (hs_term_en && !pullup_en));

    // R8: leaving high speed restores full-speed loading
    p_hs_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(speed_hs) |-> (pullup_en && !hs_term_en));

    // R9: suspend event raises the suspended flag; events are exclusive
    p_susp_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_evt |-> suspended);
    p_evt_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reset_evt && suspend_evt));

    // R12: loads exclusive, no chirp while in high speed
    p_load_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pullup_en && hs_term_en));
    p_no_hs_chirp_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(chirp_k_drive && speed_hs));

endmodule

bind hs_negotiator hsneg_checker #(
    .CHIRP_CYC (CHIRP_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chirp_k_drive (chirp_k_drive),
    .pullup_en     (pullup_en),
    .hs_term_en    (hs_term_en),
    .speed_hs      (speed_hs),
    .suspended     (suspended),
    .reset_evt     (reset_evt),
    .suspend_evt   (suspend_evt)
);

// File: tb/hs_negotiator_tb.sv
module hs_negotiator_tb;

    localparam int CHIRP_CYC = 48;
    localparam int HUB_WAIT  = 200;
    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] LJ  = 2'b01;
    localparam logic [1:0] LK  = 2'b10;

    typedef enum {EV_RESET, EV_SUSPEND, EV_HS_UP, EV_HS_DOWN} ev_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_state = 2'b01;
    logic       chirp_k_drive, pullup_en, hs_term_en, speed_hs;
    logic       suspended, reset_evt, suspend_evt;

    int   checks = 0;
    int   fails  = 0;
    ev_t  exp_q[$];
    logic prev_speed = 1'b0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    hs_negotiator u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_state    (line_state),
        .chirp_k_drive (chirp_k_drive),
        .pullup_en     (pullup_en),
        .hs_term_en    (hs_term_en),
        .speed_hs      (speed_hs),
        .suspended     (suspended),
        .reset_evt     (reset_evt),
        .suspend_evt   (suspend_evt)
    );

    function automatic string req_of(ev_t e);
        case (e)
            EV_RESET:   return "R2/R9";
            EV_SUSPEND: return "R10/R9";
            EV_HS_UP:   return "R5";
            default:    return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Monitor: pops the scoreboard as events appear at the ports
    task automatic got(input ev_t e);
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL %s unexpected event actual=%s expected=none", req_of(e), e.name());
        end else begin
            ev_t x;
            x = exp_q.pop_front();
            if (x != e) begin
                fails++;
                $display("FAIL %s event order actual=%s expected=%s", req_of(x), e.name(), x.name());
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (reset_evt)   got(EV_RESET);
            if (suspend_evt) got(EV_SUSPEND);
            if (speed_hs && !prev_speed) got(EV_HS_UP);
            if (!speed_hs && prev_speed) got(EV_HS_DOWN);
            prev_speed = speed_hs;
        end
    end

    task automatic drive(input logic [1:0] ls, input int n);
        line_state = ls;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wait_chirp(input logic lvl, input string req);
        int n = 0;
        while (chirp_k_drive !== lvl && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(chirp_k_drive === lvl, req, chirp_k_drive, lvl);
    endtask

    task automatic wait_speed(input logic lvl, input string req);
        int n = 0;
        while (speed_hs !== lvl && n < 2000) begin
            @(negedge clk);
            n++;
        end
        check(speed_hs === lvl, req, speed_hs, lvl);
    endtask

    task automatic hub_train();
        for (int i = 0; i < 3; i++) begin
            drive(LK, 12);
            drive(LJ, 12);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle full-speed state out of reset
        check(speed_hs == 0,      "R1 speed_hs", speed_hs, 0);
        check(pullup_en == 1,     "R1 pullup_en", pullup_en, 1);
        check(hs_term_en == 0,    "R1 hs_term_en", hs_term_en, 0);
        check(chirp_k_drive == 0, "R1 chirp", chirp_k_drive, 0);
        check(suspended == 0,     "R1 suspended", suspended, 0);
        check(!reset_evt && !suspend_evt, "R1 events", reset_evt, 0);
        @(posedge clk); #1;

        // R2 short SE0 is not a reset; R10 long J is a suspend
        drive(LJ, 20);
        drive(SE0, 30);
        check(chirp_k_drive == 0, "R2 short SE0 no chirp", chirp_k_drive, 0);
        exp_q.push_back(EV_SUSPEND);
        drive(LJ, 120);
        @(negedge clk);
        check(suspended == 1, "R10 suspended", suspended, 1);
        check(pullup_en == 1, "R10 pullup kept", pullup_en, 1);
        @(posedge clk); #1;

        // R11 resume reruns the handshake; R7 silent hub falls back
        drive(LK, 20);
        drive(LJ, 2);
        line_state = SE0;
        wait_chirp(1'b1, "R11 chirp after resume");
        check(suspended == 0, "R11 suspended cleared", suspended, 0);
        wait_chirp(1'b0, "R3 chirp end");
        repeat (HUB_WAIT + 10) @(negedge clk);
        check(speed_hs == 0,   "R7 fallback speed", speed_hs, 0);
        check(pullup_en == 1,  "R7 fallback pullup", pullup_en, 1);
        check(hs_term_en == 0, "R7 fallback term", hs_term_en, 0);
        @(posedge clk); #1;
        drive(SE0, 150);
        @(negedge clk);
        check(chirp_k_drive == 0, "R7 no second reset", chirp_k_drive, 0);
        @(posedge clk); #1;

        // R2 re-armed reset, R3 chirp length, R4/R6 qualification order
        drive(LJ, 10);
        exp_q.push_back(EV_RESET);
        line_state = SE0;
        wait_chirp(1'b1, "R2 chirp after reset");
        begin
            int n = 0;
            while (chirp_k_drive === 1'b1 && n < 1000) begin
                n++;
                @(negedge clk);
            end
            check(n == CHIRP_CYC, "R3 chirp length", n, CHIRP_CYC);
        end
        @(posedge clk); #1;
        drive(LK, 12);
        drive(LJ, 3);
        drive(SE0, 3);
        drive(LK, 12);
        drive(LJ, 12);
        drive(LK, 12);
        drive(LJ, 12);
        drive(LK, 12);
        @(negedge clk);
        check(speed_hs == 0, "R4 R6 restart after repeat", speed_hs, 0);
        @(posedge clk); #1;
        exp_q.push_back(EV_HS_UP);
        drive(LJ, 12);
        drive(SE0, 3);
        @(negedge clk);
        check(speed_hs == 1,   "R5 hs entered", speed_hs, 1);
        check(pullup_en == 0,  "R5 pullup off", pullup_en, 0);
        check(hs_term_en == 1, "R5 term on", hs_term_en, 1);
        @(posedge clk); #1;

        // R8 activity keeps HS, idle reverts; R9 reset branch
        for (int i = 0; i < 3; i++) begin
            drive(SE0, 60);
            drive(LJ, 5);
        end
        @(negedge clk);
        check(speed_hs == 1, "R8 activity keeps hs", speed_hs, 1);
        exp_q.push_back(EV_HS_DOWN);
        exp_q.push_back(EV_RESET);
        line_state = SE0;
        wait_speed(1'b0, "R8 idle revert");
        check(pullup_en == 1 && hs_term_en == 0, "R8 fs loads", pullup_en, 1);
        wait_chirp(1'b1, "R9 reset chirp");
        wait_chirp(1'b0, "R3 chirp end");
        @(posedge clk); #1;
        exp_q.push_back(EV_HS_UP);
        hub_train();
        drive(SE0, 4);
        @(negedge clk);
        check(speed_hs == 1, "R5 clean train", speed_hs, 1);
        @(posedge clk); #1;

        // R9 suspend branch
        exp_q.push_back(EV_HS_DOWN);
        exp_q.push_back(EV_SUSPEND);
        wait_speed(1'b0, "R8 idle revert");
        @(posedge clk); #1;
        line_state = LJ;
        repeat (40) @(negedge clk);
        check(suspended == 1, "R9 suspend after revert", suspended, 1);
        check(pullup_en == 1, "R9 pullup in suspend", pullup_en, 1);
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
        finish_up();
    end

endmodule